// File: doc/BRIEF.md
# Test Access Port Controller with 16-bit Instruction Register

This block is the serial test port of a chip. A sixteen-state controller, stepped by the mode input on each rising test clock, moves between instruction scans and data scans. The instruction register is sixteen bits wide. A small decoder maps its active value onto one of three data paths: a one-bit bypass stage, a 32-bit identification register, or an external boundary chain. The boundary chain is not part of this block. The block drives it through capture, shift, update and mode strobes, and it takes the chain's serial output back in.

Serial data enters on the rising clock edge. The serial output is registered on the falling edge and is enabled only while a shift state is active. The identification word carries a fixed part number and a fixed manufacturer code. Its top nibble is a module parameter. The reset state, entered either through the asynchronous reset or by holding the mode input high, always leaves the identification register selected.

Top module: `tap_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state mode-input transition graph, and five rising edges with tms_i high reach the reset state from any state.
- R2: While rst_ni is low, the controller is held in the reset state, the active instruction is the identification opcode, tdo_en_o is 0 and bsr_mode_o is 0.
- R3: Every entry into the reset state, whether by the mode input or by rst_ni, makes the identification opcode 0x0004 the active instruction.
- R4: The instruction shift register is 16 bits wide and loads 0x0001 in Capture-IR. It shifts out least significant bit first, with tdi_i entering at bit 15.
- R5: The active instruction changes only at the edge that leaves Update-IR, or in the reset state. Shifting in a new opcode has no effect until then.
- R6: Opcode 0xFFFF selects bypass, 0x0000 selects external test, 0x0002 selects sample/preload, and 0x0004 selects identification. Every other opcode behaves as bypass.
- R7: The bypass path is one bit long and captures 0 in Capture-DR, so a data scan returns the input delayed by one clock.
- R8: The identification register captures {version[3:0], 16'h0006, 11'b00100100001, 1'b1}, from bit 31 down to bit 0. The version field is the Version parameter.
- R9: Under external test and sample/preload, tdo_o in Shift-DR comes from bsr_tdo_i. bsr_capture_o, bsr_shift_o and bsr_update_o are high in Capture-DR, Shift-DR and Update-DR respectively. Under any other instruction these strobes stay low.
- R10: bsr_mode_o is high exactly when external test (0x0000) is the active instruction.
- R11: tdo_o and tdo_en_o change only on the falling clock edge. tdo_en_o is high only during Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select, sampled on the rising edge |
| tdi_i | input | 1 | Serial data in, sampled on the rising edge |
| tdo_o | output | 1 | Serial data out, updated on the falling edge |
| tdo_en_o | output | 1 | Output enable for tdo_o |
| bsr_tdo_i | input | 1 | Serial output of the external boundary chain |
| bsr_capture_o | output | 1 | Boundary chain capture strobe |
| bsr_shift_o | output | 1 | Boundary chain shift strobe |
| bsr_update_o | output | 1 | Boundary chain update strobe |
| bsr_mode_o | output | 1 | Boundary cells drive pins (external test active) |

## Verification
Two things share one rising edge. The final bit of a scan is shifted with tms_i high, so the same edge moves the controller to Exit1 and ends the scan. At the falling edge that follows, the output enable must drop without losing that last bit. The bench ends every scan this way and compares the complete word for each decoded path. A second collision is a five-edge reset driven from Shift-DR under a bypass instruction: the traversal passes through Update-DR, yet the active instruction must still end up as identification. The bench judges this by the 32-bit word a following data scan returns.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int unsigned IR_W = 16;
  localparam int unsigned ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 16'h0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 16'h0002;
  localparam logic [IR_W-1:0] OP_IDCODE  = 16'h0004;
  localparam logic [IR_W-1:0] OP_BYPASS  = 16'hFFFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 16'h0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BOUNDARY, PATH_BYPASS, PATH_IDENT
  } dr_path_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int unsigned IrWidth = IR_W
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  logic               tdi_i,
  output logic [IrWidth-1:0] sr_o,
  output logic [IrWidth-1:0] active_o,
  output dr_path_e           path_o,
  output logic               extest_o
);
  logic [IrWidth-1:0] sr_q, active_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= IR_CAPTURE;
      active_q <= OP_IDCODE;
    end else begin
      if (state_i == ST_CAP_IR)     sr_q <= IR_CAPTURE;
      else if (state_i == ST_SH_IR) sr_q <= {tdi_i, sr_q[IrWidth-1:1]};

      if (state_i == ST_TLR)        active_q <= OP_IDCODE;
      else if (state_i == ST_UPD_IR) active_q <= sr_q;
    end
  end

  // unknown opcodes fall through to bypass
  always_comb begin
    path_o   = PATH_BYPASS;
    extest_o = 1'b0;
    if (active_q == OP_EXTEST) begin
      path_o   = PATH_BOUNDARY;
      extest_o = 1'b1;
    end else if (active_q == OP_SAMPLE) begin
      path_o = PATH_BOUNDARY;
    end else if (active_q == OP_IDCODE) begin
      path_o = PATH_IDENT;
    end
  end

  assign sr_o     = sr_q;
  assign active_o = active_q;
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter logic [3:0]  Version = 4'h0,
  parameter logic [15:0] PartNum = 16'h0006,
  parameter logic [10:0] MfrCode = 11'b00100100001
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       byp_o,
  output logic       id_o
);
  localparam logic [ID_W-1:0] IdWord = {Version, PartNum, MfrCode, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= IdWord;
    end else if (state_i == ST_CAP_DR) begin
      byp_q <= 1'b0;
      id_q  <= IdWord;
    end else if (state_i == ST_SH_DR) begin
      byp_q <= tdi_i;
      id_q  <= {tdi_i, id_q[ID_W-1:1]};
    end
  end

  assign byp_o = byp_q;
  assign id_o  = id_q[0];
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter logic [3:0]  Version = 4'h0,
  parameter logic [15:0] PartNum = 16'h0006,
  parameter logic [10:0] MfrCode = 11'b00100100001
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_en_o,
  input  logic bsr_tdo_i,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o,
  output logic bsr_mode_o
);
  tap_state_e       state_q;
  logic [IR_W-1:0]  ir_sr, ir_active;
  dr_path_e         path;
  logic             extest;
  logic             byp_q, id_bit;
  logic             tdo_d, tdo_q, en_q;
  logic             bsr_sel;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state_q)
  );

  tap_ir #(.IrWidth(IR_W)) u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state_q),
    .tdi_i   (tdi_i),
    .sr_o    (ir_sr),
    .active_o(ir_active),
    .path_o  (path),
    .extest_o(extest)
  );

  tap_dr #(.Version(Version), .PartNum(PartNum), .MfrCode(MfrCode)) u_dr (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .state_i(state_q),
    .tdi_i  (tdi_i),
    .byp_o  (byp_q),
    .id_o   (id_bit)
  );

  assign bsr_sel = (path == PATH_BOUNDARY);

  always_comb begin
    unique case (path)
      PATH_BOUNDARY: tdo_d = bsr_tdo_i;
      PATH_IDENT:    tdo_d = id_bit;
      default:       tdo_d = byp_q;
    endcase
    if (state_q == ST_SH_IR) tdo_d = ir_sr[0];
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      en_q  <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
    end
  end

  assign tdo_o         = tdo_q;
  assign tdo_en_o      = en_q;
  assign bsr_capture_o = bsr_sel && (state_q == ST_CAP_DR);
  assign bsr_shift_o   = bsr_sel && (state_q == ST_SH_DR);
  assign bsr_update_o  = bsr_sel && (state_q == ST_UPD_DR);
  assign bsr_mode_o    = extest;
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            tdo_en_o,
  input logic            bsr_capture_o,
  input logic            bsr_shift_o,
  input logic            bsr_update_o,
  input logic            bsr_mode_o,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_active,
  input logic            byp_q
);
  AST_TLR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> state_q == ST_TLR); // R1

  AST_TLR_IDCODE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR) |=> ir_active == OP_IDCODE); // R3

  AST_IR_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_CAP_IR) |=> ir_sr == IR_CAPTURE); // R4

  AST_IR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q != ST_UPD_IR && state_q != ST_TLR) |=> $stable(ir_active)); // R5

  AST_BYP_CAPTURE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_CAP_DR) |=> !byp_q); // R7

  AST_STROBE_EXCL: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o})); // R9

  AST_MODE_EXTEST: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bsr_mode_o |-> ir_active == OP_EXTEST); // R10

  AST_EN_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state_q == ST_SH_IR || state_q == ST_SH_DR)); // R11
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .tms_i        (tms_i),
  .tdo_en_o     (tdo_en_o),
  .bsr_capture_o(bsr_capture_o),
  .bsr_shift_o  (bsr_shift_o),
  .bsr_update_o (bsr_update_o),
  .bsr_mode_o   (bsr_mode_o),
  .state_q      (state_q),
  .ir_sr        (ir_sr),
  .ir_active    (ir_active),
  .byp_q        (byp_q)
);

// File: tb/tb_tap_ctrl.sv
module tb_tap_ctrl;
  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tms_i = 1'b1;
  logic tdi_i = 1'b0;
  logic tdo_o, tdo_en_o, bsr_tdo_i;
  logic bsr_capture_o, bsr_shift_o, bsr_update_o, bsr_mode_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] EXP_ID = 32'hA000_6243;
  localparam logic [31:0] PAT    = 32'hC3A5_0F96;
  localparam int NV = 7;
  localparam logic [15:0] V_OP   [NV] = '{16'hFFFF, 16'h0000, 16'h0002, 16'h0004, 16'h1234, 16'h8001, 16'h0006};
  localparam logic [1:0]  V_PATH [NV] = '{2'd1, 2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd1};
  localparam logic        V_MODE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  always #2 tck = ~tck;

  tap_ctrl #(.Version(4'hA)) dut (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .bsr_tdo_i(bsr_tdo_i),
    .bsr_capture_o(bsr_capture_o), .bsr_shift_o(bsr_shift_o),
    .bsr_update_o(bsr_update_o), .bsr_mode_o(bsr_mode_o)
  );

  // stand-in boundary chain
  logic [7:0] bchain = 8'h00;
  always @(posedge tck) begin
    if (bsr_capture_o)    bchain <= 8'hA5;
    else if (bsr_shift_o) bchain <= {tdi_i, bchain[7:1]};
  end
  assign bsr_tdo_i = bchain[0];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic tms, input logic tdi);
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      step(i == n - 1, din[i]);
    end
  endtask

  task automatic load_ir(input logic [15:0] op, output logic [31:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift(16, {16'h0, op}, cap);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    shift(n, din, dout);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [31:0] exp_dr(input logic [1:0] path, input logic [31:0] din);
    case (path)
      2'd0:    return {din[23:0], 8'hA5};
      2'd2:    return EXP_ID;
      default: return {din[30:0], 1'b0};
    endcase
  endfunction

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #5;
    chk("R2 tdo_en in reset", {31'b0, tdo_en_o}, 0);
    chk("R2 mode in reset", {31'b0, bsr_mode_o}, 0);
    chk("R9 strobes in reset", {29'b0, bsr_capture_o, bsr_shift_o, bsr_update_o}, 0);
    @(negedge tck); #1;
    rst_ni = 1'b1;
    step(1, 0); step(0, 0);
    chk("R11 tdo_en idle", {31'b0, tdo_en_o}, 0);

    scan_dr(32, PAT, d);
    chk("R3 R8 idcode after reset", d, EXP_ID);

    // table walk
    for (int v = 0; v < NV; v++) begin
      load_ir(V_OP[v], d);
      chk("R4 ir capture", d, 32'h0000_0001);
      chk("R10 mode", {31'b0, bsr_mode_o}, {31'b0, V_MODE[v]});
      scan_dr(32, PAT, d);
      chk("R6 R7 R8 R9 dr path", d, exp_dr(V_PATH[v], PAT));
    end

    // R9 R11: enable high in shift, capture strobe
    load_ir(16'h0000, d);
    step(1, 0); step(0, 0);
    chk("R9 capture strobe", {31'b0, bsr_capture_o}, 1);
    step(0, 0);
    chk("R11 tdo_en shift", {31'b0, tdo_en_o}, 1);
    chk("R9 shift strobe", {31'b0, bsr_shift_o}, 1);
    step(1, 0); step(1, 0);
    chk("R9 update strobe", {31'b0, bsr_update_o}, 1);
    step(0, 0);

    // R5: opcode shifted in has no effect before update
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift(16, 32'h0000_FFFF, d);
    chk("R5 mode before update", {31'b0, bsr_mode_o}, 1);
    step(1, 0);
    chk("R5 mode in update", {31'b0, bsr_mode_o}, 1);
    step(0, 0);
    chk("R5 mode after update", {31'b0, bsr_mode_o}, 0);

    // R11: bypass output changes at falling edge only
    step(1, 0); step(0, 0); step(0, 0);
    chk("R7 bypass first bit", {31'b0, tdo_o}, 0);
    tms_i = 0; tdi_i = 1;
    @(posedge tck); #1;
    chk("R11 tdo held past rise", {31'b0, tdo_o}, 0);
    @(negedge tck); #1;
    chk("R11 tdo at fall", {31'b0, tdo_o}, 1);

    // R1 R3: five TMS-high edges from Shift-DR under bypass
    for (int k = 0; k < 5; k++) step(1, 0);
    chk("R1 tdo_en after five ones", {31'b0, tdo_en_o}, 0);
    step(0, 0);
    scan_dr(32, PAT, d);
    chk("R1 R3 idcode after five ones", d, EXP_ID);

    // R2: async reset during external test
    load_ir(16'h0000, d);
    chk("R10 mode before reset", {31'b0, bsr_mode_o}, 1);
    rst_ni = 1'b0;
    #0.5;
    chk("R2 mode cleared async", {31'b0, bsr_mode_o}, 0);
    @(negedge tck); #1;
    rst_ni = 1'b1;
    step(0, 0);
    scan_dr(32, PAT, d);
    chk("R2 R3 idcode after async reset", d, EXP_ID);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule